// File: doc/BRIEF.md
# Inter-function gap watchdog

This block polices the quiet intervals inside a power-sourcing detection sequence. Such a sequence runs three functions, possibly overlapping and in any order: detection on the primary pairset, detection on the secondary pairset and a connection check. Whenever a sequence is in progress in four-pair operation and none of the three functions is busy, the watchdog counts timebase ticks. If a function starts before the limit is reached, counting stops and the count is discarded. The next quiet interval is then timed again from zero.

If a quiet interval reaches the limit, the watchdog raises a sticky fault flag for the sequencer. The limit is a parameter counted in ticks of an enable input. With a 1 ms tick, the default of 400 ticks matches the permitted maximum gap of 0.4 s. Dropping the sequence-in-progress input sends the watchdog back to idle from any state. The fault flag stays set until the sequencer pulses a synchronous clear, normally from its own idle state. In two-pair operation the watchdog never arms.

Top module: `gap_watchdog`

## Requirements
- R1: While reset is active, and on the first cycle after it, `gap_fault` is 0, the watchdog is idle and the tick count is zero.
- R2: From idle, if `seq_active`=1, `four_pair`=1 and every bit of `func_busy` is 0 at a clock edge, the watchdog starts monitoring at that edge with a tick count of zero.
- R3: While monitoring, if any `func_busy` bit is 1 at an edge, the watchdog returns to idle and discards the count. Each later quiet interval is timed again from zero.
- R4: After `LIMIT_TICKS` ticks have been counted in one uninterrupted quiet interval, the next edge moves the watchdog to the fault state and sets `gap_fault`.
- R5: `seq_active`=0 at an edge returns the watchdog to idle from any state, and does not change `gap_fault`.
- R6: `gap_fault` stays 1 until `fault_clr`=1 at an edge, which clears it at that edge. If a clear and a new fault coincide, the clear wins when `CLEAR_WINS`=1.
- R7: With `four_pair`=0 the watchdog never leaves idle, so no fault can arise.
- R8: Only cycles with `tick_en`=1 advance the count. A quiet interval with no ticks never faults.
- R9: If a function starts on the same edge at which the count would expire, the function wins and no fault is raised.
- R10: In the fault state with `seq_active` held at 1, a clear leaves `gap_fault` at 0. The flag is not raised again until a new monitored interval expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timebase enable; one pulse per tick |
| seq_active | input | 1 | A detection sequence is in progress |
| four_pair | input | 1 | Power is delivered on both pairsets |
| func_busy | input | NUM_FUNC | Per-function active flags: bit 0 primary detect, bit 1 secondary detect, bit 2 connection check |
| fault_clr | input | 1 | Synchronous clear of the fault flag |
| gap_fault | output | 1 | Sticky inter-function gap fault |

## Verification
Arming happens on the first edge after a quiet interval begins. The count then advances once per tick edge. With ticks on every cycle, `gap_fault` therefore rises LIMIT_TICKS+2 edges after the inputs first show a quiet interval. Clears and sequence drops act on the very next edge. The bench drives inputs on the falling edge and advances a cycle model on each rising edge. It compares `gap_fault` at the following falling edge. The directed cases also check the exact expiry edge and the edges immediately around it.

// File: rtl/gap_wd_pkg.sv
package gap_wd_pkg;
   typedef enum logic [1:0] {
      WD_IDLE    = 2'd0,
      WD_MONITOR = 2'd1,
      WD_FAULT   = 2'd2
   } wd_state_e;
endpackage

// File: rtl/gap_wd_activity.sv
// Folds the per-function busy flags into one activity indication.
module gap_wd_activity #(
   parameter int NUM_FUNC = 3
) (
   input  logic [NUM_FUNC-1:0] func_busy,
   output logic                any_busy
);
   generate
      if (NUM_FUNC == 1) begin : g_single
         assign any_busy = func_busy[0];
      end else begin : g_multi
         assign any_busy = |func_busy;
      end
   endgenerate
endmodule

// File: rtl/gap_wd_timer.sv
// Tick counter that runs only while monitoring and saturates at the limit.
module gap_wd_timer #(
   parameter int LIMIT_TICKS = 400,
   localparam int CNT_W = $clog2(LIMIT_TICKS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick_en,
   output logic [CNT_W-1:0] count,
   output logic             expired
);
   localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT_TICKS);

   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (!run) begin
         count_q <= '0;
      end else if (tick_en && (count_q < LIMIT_V)) begin
         count_q <= count_q + 1'b1;
      end
   end

   assign count   = count_q;
   assign expired = (count_q == LIMIT_V);
endmodule

// File: rtl/gap_wd_fsm.sv
// Idle / monitor / fault control.
module gap_wd_fsm
   import gap_wd_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      seq_active,
   input  logic      four_pair,
   input  logic      any_busy,
   input  logic      expired,
   output wd_state_e state,
   output logic      monitoring,
   output logic      fault_set
);
   wd_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         WD_IDLE: begin
            if (seq_active && four_pair && !any_busy) state_d = WD_MONITOR;
         end
         WD_MONITOR: begin
            if (!seq_active)   state_d = WD_IDLE;
            else if (any_busy) state_d = WD_IDLE;
            else if (expired)  state_d = WD_FAULT;
         end
         WD_FAULT: begin
            if (!seq_active) state_d = WD_IDLE;
         end
         default: state_d = WD_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= WD_IDLE;
      else        state_q <= state_d;
   end

   assign state      = state_q;
   assign monitoring = (state_q == WD_MONITOR);
   assign fault_set  = (state_q == WD_MONITOR) && (state_d == WD_FAULT);
endmodule

// File: rtl/gap_wd_flag.sv
// Sticky fault flag; the parameter picks whether clear or set has priority.
module gap_wd_flag #(
   parameter bit CLEAR_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   logic flag_q;

   generate
      if (CLEAR_WINS) begin : g_clr_first
         always_ff @(posedge clk) begin
            if (!rst_n)   flag_q <= 1'b0;
            else if (clr) flag_q <= 1'b0;
            else if (set) flag_q <= 1'b1;
         end
      end else begin : g_set_first
         always_ff @(posedge clk) begin
            if (!rst_n)   flag_q <= 1'b0;
            else if (set) flag_q <= 1'b1;
            else if (clr) flag_q <= 1'b0;
         end
      end
   endgenerate

   assign flag = flag_q;
endmodule

// File: rtl/gap_watchdog.sv
module gap_watchdog
   import gap_wd_pkg::*;
#(
   parameter int LIMIT_TICKS = 400,
   parameter int NUM_FUNC    = 3,
   parameter bit CLEAR_WINS  = 1'b1,
   localparam int CNT_W = $clog2(LIMIT_TICKS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_en,
   input  logic                seq_active,
   input  logic                four_pair,
   input  logic [NUM_FUNC-1:0] func_busy,
   input  logic                fault_clr,
   output logic                gap_fault
);
   generate
      if (LIMIT_TICKS < 1) begin : g_bad_limit
         $error("gap_watchdog: LIMIT_TICKS must be at least 1");
      end
      if (NUM_FUNC < 1) begin : g_bad_func
         $error("gap_watchdog: NUM_FUNC must be at least 1");
      end
   endgenerate

   logic             any_busy;
   logic             expired;
   logic             monitoring;
   logic             fault_set;
   logic [CNT_W-1:0] count;
   wd_state_e        state;

   gap_wd_activity #(.NUM_FUNC(NUM_FUNC)) u_act (
      .func_busy (func_busy),
      .any_busy  (any_busy)
   );

   gap_wd_timer #(.LIMIT_TICKS(LIMIT_TICKS)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (monitoring),
      .tick_en (tick_en),
      .count   (count),
      .expired (expired)
   );

   gap_wd_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .seq_active (seq_active),
      .four_pair  (four_pair),
      .any_busy   (any_busy),
      .expired    (expired),
      .state      (state),
      .monitoring (monitoring),
      .fault_set  (fault_set)
   );

   gap_wd_flag #(.CLEAR_WINS(CLEAR_WINS)) u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (fault_set),
      .clr   (fault_clr),
      .flag  (gap_fault)
   );
endmodule

// File: rtl/gap_wd_chk.sv
module gap_wd_chk
   import gap_wd_pkg::*;
#(
   parameter int LIMIT_TICKS = 400,
   parameter int NUM_FUNC    = 3,
   parameter int CNT_W       = 9
) (
   input logic                clk,
   input logic                rst_n,
   input logic                tick_en,
   input logic                seq_active,
   input logic                four_pair,
   input logic [NUM_FUNC-1:0] func_busy,
   input logic                fault_clr,
   input logic                gap_fault,
   input wd_state_e           state,
   input logic [CNT_W-1:0]    count
);
   a_r2_arm_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WD_IDLE && seq_active && four_pair && func_busy == '0)
      |=> (state == WD_MONITOR && count == '0));

   a_r3_busy_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WD_MONITOR && func_busy != '0) |=> (state == WD_IDLE));

   a_r4_fault_from_monitor: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gap_fault) |-> ($past(state) == WD_MONITOR));

   a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WD_MONITOR) |-> (count <= CNT_W'(LIMIT_TICKS)));

   a_r5_drop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !seq_active |=> (state == WD_IDLE));

   a_r6_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (gap_fault && !fault_clr) |=> gap_fault);

   a_r6_clear_acts: assert property (@(posedge clk) disable iff (!rst_n)
      fault_clr |=> !gap_fault);

   a_r7_two_pair_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WD_IDLE && !four_pair) |=> (state == WD_IDLE));

   a_r8_no_tick_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WD_MONITOR && !tick_en) |=> $stable(count));
endmodule

bind gap_watchdog gap_wd_chk #(
   .LIMIT_TICKS (LIMIT_TICKS),
   .NUM_FUNC    (NUM_FUNC),
   .CNT_W       (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_en    (tick_en),
   .seq_active (seq_active),
   .four_pair  (four_pair),
   .func_busy  (func_busy),
   .fault_clr  (fault_clr),
   .gap_fault  (gap_fault),
   .state      (state),
   .count      (count)
);

// File: tb/gap_watchdog_test.sv
`timescale 1ns/1ps
module gap_watchdog_test;
   localparam int L = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       seq_active = 1'b0;
   logic       four_pair = 1'b0;
   logic [2:0] func_busy = 3'b000;
   logic       fault_clr = 1'b0;
   logic       gap_fault;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;

   // Cycle model: 0 idle, 1 monitor, 2 fault
   int m_st = 0;
   int m_cnt = 0;
   bit m_fault = 1'b0;

   always #4 clk = ~clk;

   gap_watchdog #(.LIMIT_TICKS(L), .NUM_FUNC(3), .CLEAR_WINS(1'b1)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_en    (tick_en),
      .seq_active (seq_active),
      .four_pair  (four_pair),
      .func_busy  (func_busy),
      .fault_clr  (fault_clr),
      .gap_fault  (gap_fault)
   );

   function automatic int next_state(int st, int cnt, bit seq, bit fp, bit busy);
      case (st)
         0: return (seq && fp && !busy) ? 1 : 0;
         1: if (!seq || busy) return 0; else if (cnt == L) return 2; else return 1;
         default: return seq ? 2 : 0;
      endcase
   endfunction

   function automatic int next_count(int st, int cnt, bit tick);
      if (st != 1) return 0;
      return (tick && cnt < L) ? cnt + 1 : cnt;
   endfunction

   task automatic check(bit exp, string tag);
      vectors++;
      if (gap_fault !== exp) begin
         fails++;
         $display("FAIL %s: gap_fault=%0b expected=%0b", tag, gap_fault, exp);
      end
   endtask

   // One rising edge: advance the model, then compare at the falling edge.
   task automatic cyc(string tag);
      int ns;
      bit enter;
      @(posedge clk);
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_fault = 1'b0;
      end else begin
         ns = next_state(m_st, m_cnt, seq_active, four_pair, |func_busy);
         enter = (m_st == 1) && (ns == 2);
         m_cnt = next_count(m_st, m_cnt, tick_en);
         m_st = ns;
         if (fault_clr) m_fault = 1'b0;
         else if (enter) m_fault = 1'b1;
      end
      @(negedge clk);
      check(m_fault, tag);
   endtask

   task automatic drive(bit seq, bit fp, logic [2:0] busy, bit tick, bit clr);
      seq_active = seq; four_pair = fp; func_busy = busy; tick_en = tick; fault_clr = clr;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run hung, actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      // R1: reset state
      repeat (3) cyc("R1 in reset");
      @(negedge clk); rst_n = 1'b1;
      check(1'b0, "R1 after reset");
      cyc("R1 first cycle");

      // R2/R4: quiet interval with a tick every cycle, exact expiry edge
      drive(1, 1, 3'b000, 1, 0);
      repeat (L + 1) cyc("R2 monitoring");
      check(1'b0, "R4 one edge before expiry");
      cyc("R4 expiry edge");
      check(1'b1, "R4 fault set");

      // R6/R5: fault sticky, survives sequence drop, cleared by pulse
      repeat (5) cyc("R6 sticky");
      drive(0, 1, 3'b000, 1, 0);
      repeat (3) cyc("R5 drop keeps flag");
      check(1'b1, "R5 flag after drop");
      drive(0, 1, 3'b000, 1, 1);
      cyc("R6 clear");
      check(1'b0, "R6 cleared");
      drive(0, 1, 3'b000, 1, 0);
      cyc("R5 idle");

      // R8: quiet interval without ticks never faults
      drive(1, 1, 3'b000, 0, 0);
      repeat (50) cyc("R8 no ticks");
      check(1'b0, "R8 no fault");
      drive(0, 1, 3'b000, 0, 0);
      cyc("R8 leave");

      // R3/R9: gaps cut exactly at expiry by a starting function
      for (int g = 0; g < 5; g++) begin
         drive(1, 1, 3'b000, 1, 0);
         repeat (L + 1) cyc("R3 gap");
         drive(1, 1, 3'b001 << (g % 3), 1, 0);
         cyc("R9 busy at expiry");
      end
      check(1'b0, "R3 re-armed gaps no fault");
      drive(1, 1, 3'b010, 1, 0);
      cyc("R3 busy");

      // R7: two-pair never arms
      drive(1, 0, 3'b000, 1, 0);
      repeat (30) cyc("R7 two-pair");
      check(1'b0, "R7 no fault");

      // R6: clear coincides with a new fault, clear wins
      drive(1, 1, 3'b000, 1, 0);
      repeat (L + 1) cyc("R6 gap");
      drive(1, 1, 3'b000, 1, 1);
      cyc("R6 clear vs set");
      check(1'b0, "R6 clear wins");

      // R10: fault state with sequence held, clear stays low
      drive(1, 1, 3'b000, 1, 0);
      repeat (20) cyc("R10 held in fault");
      check(1'b0, "R10 no retrigger");
      drive(0, 1, 3'b000, 1, 0);
      cyc("R10 leave");
      drive(1, 1, 3'b000, 1, 0);
      repeat (L + 2) cyc("R10 new gap");
      check(1'b1, "R10 new fault");
      drive(1, 1, 3'b000, 1, 1);
      cyc("R10 clear in fault");
      drive(1, 1, 3'b000, 1, 0);
      repeat (20) cyc("R10 stays low");
      check(1'b0, "R10 still low");

      // R2..R9 mixed: constrained random against the cycle model
      for (int i = 0; i < 4000; i++) begin
         drive(($urandom % 16) != 0, ($urandom % 8) != 0,
               (($urandom % 10) == 0) ? 3'($urandom) : 3'b000,
               ($urandom % 2) == 0, ($urandom % 40) == 0);
         cyc("R4 random");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule